// File: doc/BRIEF.md
# Selectable Multi-Channel Input Debouncer

This block takes a group of raw, already-digitized field levels and turns each one into a validated level. Every raw bit is first brought into the clock domain through two flops. A persistence filter then accepts a new level, high or low, only after it has stayed put for the whole of the chosen hold time. The hold time comes from a 2-bit select and is counted in millisecond ticks. A shared prescaler derives those ticks from the system clock, whose frequency is a parameter.

One select code turns the filter off. In that mode the synchronized level goes straight to the output, so fast serial-rate signals still get through. The validated outputs are meant to feed a parallel-load shift register. Each channel keeps its own counter, so a bouncing contact on one input never delays or disturbs another.

Top module: `multi_input_debouncer`

## Requirements
- R1: Each of the NUM_CH channels filters on its own: activity on one raw input never changes another channel's validated output or its timing.
- R2: While rst_n is low, every validated output, every channel counter and the tick prescaler are held at zero, and the latched select is held at the 3 ms setting (code 2'b11).
- R3: Each raw input passes through two synchronizing flops before any filter logic sees it. In bypass mode, a raw level that is present before clock edge k appears on clean_out after edge k+2.
- R4: With DIV = CLK_HZ/1000, the prescaler raises a one-cycle tick once every DIV cycles. The first tick is high during the DIV-th cycle after reset is released.
- R5: In filter mode with hold H ticks, a synchronized level that differs from the validated level is taken over at the clock edge of the (H+1)-th tick during which it has differed without a break. It therefore always holds for at least H full milliseconds.
- R6: If the synchronized level returns to the validated level before acceptance, the channel counter restarts from zero, and the output does not change.
- R7: The persistence rule treats low-to-high and high-to-low changes the same way.
- R8: Select encoding: 2'b11 gives a 3-tick hold, 2'b10 gives a 1-tick hold, and 2'b01 selects bypass.
- R9: Select code 2'b00 behaves exactly like 2'b11 (3-tick hold).
- R10: dly_sel is sampled only at the clock edge of a tick. A select change therefore takes effect at the next counting interval and never moves an output on its own.
- R11: In bypass mode the output follows the synchronized level every cycle, whatever the tick phase, and channel counters stay at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CLK_HZ hertz |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | NUM_CH | Unsynchronized raw channel levels |
| dly_sel | input | 2 | Hold-time select, encoding in R8 and R9 |
| clean_out | output | NUM_CH | Validated levels, one per channel |

## Verification
Clean single steps in both directions, under each hold setting, show whether acceptance happens at the right tick and not one early. A level checked a few cycles short of the window tells an on-time design from an early one. Short pulses on one channel, shorter than two tick periods, show whether the counter restarts, as opposed to a counter that keeps adding up across bounces. Staggered per-channel toggle rates and a free-running pseudo-random mix with select changes at arbitrary phases separate shared filter state from per-channel state and show when a select change lands. A behavioural model compares clean_out against this on every clock.

// File: rtl/deb_pkg.sv
package deb_pkg;

  typedef enum logic [1:0] {
    SEL_RSVD   = 2'b00,
    SEL_BYPASS = 2'b01,
    SEL_1MS    = 2'b10,
    SEL_3MS    = 2'b11
  } dly_sel_e;

  localparam int HOLD_W = 2;

  // Number of millisecond ticks a new level must outlast (reserved code maps to 3)
  function automatic logic [HOLD_W-1:0] sel_hold_ticks(input logic [1:0] s);
    case (dly_sel_e'(s))
      SEL_1MS:    sel_hold_ticks = 2'd1;
      SEL_BYPASS: sel_hold_ticks = 2'd0;
      default:    sel_hold_ticks = 2'd3;
    endcase
  endfunction

  function automatic logic sel_is_bypass(input logic [1:0] s);
    sel_is_bypass = (dly_sel_e'(s) == SEL_BYPASS);
  endfunction

endpackage

// File: rtl/deb_tick_gen.sv
module deb_tick_gen #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(DIV - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap_chk
      AST_TICK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R4
    end
  endgenerate

endmodule

// File: rtl/deb_sync.sv
module deb_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;

endmodule

// File: rtl/deb_channel.sv
module deb_channel
  import deb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_i,
  input  logic              tick_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic              bypass_i,
  output logic              clean_o
);
  logic [HOLD_W-1:0] run_q;
  logic              differs;
  logic              expire;

  assign differs = (lvl_i != clean_o);
  assign expire  = differs && tick_i && (run_q >= hold_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clean_o <= 1'b0;
      run_q   <= '0;
    end else if (bypass_i) begin
      clean_o <= lvl_i;
      run_q   <= '0;
    end else if (!differs) begin
      run_q   <= '0;
    end else if (expire) begin
      clean_o <= lvl_i;
      run_q   <= '0;
    end else if (tick_i) begin
      run_q   <= run_q + 1'b1;
    end
  end

  AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_i |=> (clean_o == $past(lvl_i))); // R11

  AST_MATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_i && (lvl_i == clean_o)) |=> $stable(clean_o)); // R6

  AST_FILTER_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_i && !tick_i) |=> $stable(clean_o)); // R5

endmodule

// File: rtl/multi_input_debouncer.sv
module multi_input_debouncer
  import deb_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] raw_in,
  input  logic [1:0]        dly_sel,
  output logic [NUM_CH-1:0] clean_out
);
  localparam int DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

  logic              ms_tick;
  logic [NUM_CH-1:0] lvl_sync;
  logic [1:0]        sel_q;
  logic [HOLD_W-1:0] hold_ticks;
  logic              bypass;

  deb_tick_gen #(.DIV(DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (ms_tick)
  );

  deb_sync #(.W(NUM_CH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (lvl_sync)
  );

  // Select is adopted only at tick boundaries
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_q <= SEL_3MS;
    else if (ms_tick) sel_q <= dly_sel;
  end

  assign hold_ticks = sel_hold_ticks(sel_q);
  assign bypass     = sel_is_bypass(sel_q);

  generate
    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
      deb_channel u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (lvl_sync[gi]),
        .tick_i   (ms_tick),
        .hold_i   (hold_ticks),
        .bypass_i (bypass),
        .clean_o  (clean_out[gi])
      );
    end
  endgenerate

  AST_SEL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_tick |=> $stable(sel_q)); // R10

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lvl_sync == $past(u_sync.meta_q))); // R3

endmodule

// File: tb/multi_input_debouncer_tb.sv
`timescale 1ns/1ps
module multi_input_debouncer_tb;
  localparam int NCH = 8;
  localparam int CLK_HZ = 8000;
  localparam int DIV = CLK_HZ / 1000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] raw_in = '0;
  logic [1:0]     dly_sel = 2'b11;
  logic [NCH-1:0] clean_out;

  int n_chk = 0;
  int n_bad = 0;
  string phase = "R2";
  bit finished = 0;

  always #2.5 clk = ~clk;

  multi_input_debouncer #(.NUM_CH(NCH), .CLK_HZ(CLK_HZ), .TICK_HZ(1000)) u_dut (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .dly_sel(dly_sel), .clean_out(clean_out)
  );

  // Behavioural reference model
  int           m_tcnt;
  int           m_cnt [NCH];
  bit [NCH-1:0] m_out, m_s1, m_s2;
  bit [1:0]     m_sel;
  bit           m_tk, m_byp;
  int           m_lim;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tcnt = 0; m_out = '0; m_s1 = '0; m_s2 = '0; m_sel = 2'b11;
      for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
    end else begin
      m_tk   = (m_tcnt == DIV - 1);
      m_tcnt = m_tk ? 0 : m_tcnt + 1;
      m_byp  = (m_sel == 2'b01);
      m_lim  = (m_sel == 2'b10) ? 1 : 3;
      for (int i = 0; i < NCH; i++) begin
        if (m_byp) begin
          m_out[i] = m_s2[i]; m_cnt[i] = 0;
        end else if (m_s2[i] == m_out[i]) begin
          m_cnt[i] = 0;
        end else if (m_tk) begin
          if (m_cnt[i] >= m_lim) begin m_out[i] = m_s2[i]; m_cnt[i] = 0; end
          else m_cnt[i] = m_cnt[i] + 1;
        end
      end
      if (m_tk) m_sel = dly_sel;
      m_s2 = m_s1;
      m_s1 = raw_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_chk++;
      if (clean_out !== m_out) begin
        n_bad++;
        $display("FAIL %s clean_out actual %h expected %h at %0t", phase, clean_out, m_out, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [NCH-1:0] got, input logic [NCH-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  bit [15:0] lfsr = 16'hACE1;
  function automatic bit [15:0] step(input bit [15:0] v);
    step = {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset", clean_out, '0);

    phase = "R8";
    dly_sel = 2'b01; cyc(10);
    raw_in = 8'hA5; cyc(3);
    chk("R3 bypass latency", clean_out, 8'hA5);
    phase = "R11";
    for (int k = 0; k < 24; k++) begin
      lfsr = step(lfsr); raw_in = lfsr[7:0]; @(negedge clk);
    end
    raw_in = 8'h00; cyc(4);

    phase = "R4";
    dly_sel = 2'b10; cyc(10);
    raw_in = 8'h0F; cyc(30);
    chk("R5 1ms accept", clean_out, 8'h0F);

    phase = "R5";
    dly_sel = 2'b11; cyc(10);
    raw_in = 8'hF0; cyc(20);
    chk("R5 not early", clean_out, 8'h0F);
    cyc(20);
    chk("R5 3ms accept", clean_out, 8'hF0);

    phase = "R7";
    raw_in = 8'h00; cyc(40);
    chk("R7 falling accept", clean_out, 8'h00);

    phase = "R6";
    dly_sel = 2'b10; cyc(10);
    for (int k = 0; k < 6; k++) begin
      raw_in = 8'h01; cyc(6);
      raw_in = 8'h00; cyc(2);
    end
    chk("R6 bounce rejected", clean_out, 8'h00);

    phase = "R9";
    dly_sel = 2'b00; cyc(10);
    raw_in = 8'h3C; cyc(20);
    chk("R9 not early", clean_out, 8'h00);
    cyc(20);
    chk("R9 3ms accept", clean_out, 8'h3C);

    phase = "R10";
    dly_sel = 2'b11; cyc(10);
    raw_in = 8'hC3; dly_sel = 2'b01; cyc(5);
    dly_sel = 2'b10; cyc(40);
    chk("R10 settled", clean_out, 8'hC3);

    phase = "R1";
    for (int k = 1; k <= 600; k++) begin
      for (int c = 0; c < NCH; c++)
        if (k % (3 + 4 * c) == 0) raw_in[c] = ~raw_in[c];
      @(negedge clk);
    end

    phase = "R5";
    for (int k = 0; k < 800; k++) begin
      lfsr = step(lfsr);
      if (lfsr[3:0] == 4'h0) dly_sel = lfsr[9:8];
      if (lfsr[6:4] == 3'b000) raw_in = lfsr[15:8];
      @(negedge clk);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule